// File: doc/BRIEF.md
# Omega Network XOR-Tag Path Configurator

This block sets up an 8-port, three-stage Omega interconnect built from 2x2 exchange elements, four per stage, with perfect-shuffle wiring in front of every stage. The caller presents up to eight connection requests at once. Each source port has a valid bit and a 3-bit destination. When `cfg_start` is pulsed, the block does four things:

- It forms the routing tag for every valid request as source XOR destination.
- It traces that request's path through the stages.
- It claims the exchange elements on the path, visiting sources from port 0 upward.
- It records a 12-bit straight/crossed setting vector.

A request that needs an element already claimed with the opposite setting is rejected and flagged. The settings claimed by earlier requests stay in place.

The result appears one clock later, together with a one-cycle done pulse. The setting vector is then held until the next configure. A data plane carries eight parallel word lanes through the held settings. For every accepted request, the word entering on the source lane leaves on the destination lane.

The control sequence is a two-state machine:

- **IDLE**: no result is being reported. The transition START_SEEN, taken when `cfg_start` is high at a clock edge, leads to REPORT. Otherwise the block stays in IDLE.
- **REPORT**: `cfg_done` is high for that cycle. The transition RESTART, taken when `cfg_start` is high again, stays in REPORT with fresh results. Otherwise the transition RETIRE returns to IDLE.

Top module: `omega_xor_router`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, `switch_set`, `accept_mask` and `conflict_mask` become all zero, and `cfg_done` becomes 0.
- R2: When `cfg_start` is sampled high at an edge, `cfg_done` is 1 during the following cycle and the new results are visible in that same cycle. Without another start, `cfg_done` returns to 0 one cycle later.
- R3: For a request from source `s` to destination `d`, the tag is `s ^ d`. Stage k (k = 0 is the first stage) uses tag bit 2-k, where 0 means straight and 1 means crossed. Element e of stage k is reported in `switch_set[4*k+e]`, with 1 meaning crossed.
- R4: The path of a request is traced as follows:
  - The line index starts at the source.
  - At each stage the line index is rotated left by one bit.
  - The element used is the line index shifted right by one.
  - The line's low bit is then XORed with that stage's tag bit.

  For example, source 1 to destination 2 claims element 1 of stage 0 straight, element 2 of stage 1 crossed and element 1 of stage 2 crossed, giving `switch_set` = 0x240.
- R5: Requests are resolved in ascending source order. Source 0, if valid, is always accepted. A later request that meets an element already claimed with the opposite setting is rejected: its `conflict_mask` bit is set and its `accept_mask` bit is clear.
- R6: A rejected request claims no element. Every element not claimed by an accepted request is reported straight (0).
- R7: A source whose valid bit is clear takes no part. Its accept and conflict bits are 0, and it cannot block later requests.
- R8: At done, `accept_mask` and `conflict_mask` are disjoint, and their OR equals the valid mask that was sampled with the start.
- R9: Without a new start, `switch_set`, `accept_mask` and `conflict_mask` hold their values whatever the request inputs do.
- R10: For every accepted request from s to d, `data_out` lane d equals `data_in` lane s, with lane j occupying bits [16j+15:16j]. The data path is combinational through the held settings.
- R11: A single valid request is always accepted, for every one of the 64 source/destination pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_start | input | 1 | Configure strobe; requests are sampled on the same edge |
| req_valid | input | 8 | Per-source request valid |
| req_dst | input | 24 | Destination of source j in bits [3j+2:3j] |
| data_in | input | 128 | Eight 16-bit input lanes, lane j at bits [16j+15:16j] |
| cfg_done | output | 1 | One-cycle pulse after a configure |
| accept_mask | output | 8 | Sources whose path was established |
| conflict_mask | output | 8 | Sources rejected because of an element clash |
| switch_set | output | 12 | Element settings, bit 4k+e for element e of stage k, 1 = crossed |
| data_out | output | 128 | Eight 16-bit output lanes routed through the settings |

## Verification
The hardest situation to reach is a clash that appears only at a late stage, after the two paths have used disjoint elements earlier. A related case is a rejected request whose partial path must leave no trace that could block a later request.

Two stimuli target this:
- Eight sources all aimed at destination 0. Only source 0 survives, and the others clash at different stages, so the claiming order decides each flag.
- A pair whose valid bit is withdrawn, so that an invalid request cannot block anything.

An exhaustive sweep of single requests then confirms that every source/destination pair routes in an idle network.

// File: rtl/omega_cfg_pkg.sv
package omega_cfg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } cfg_state_t;

endpackage

// File: rtl/omega_tag_path.sv
// Traces one request through all stages: element index and setting per stage.
module omega_tag_path #(
    parameter int LOG2 = 3
) (
    input  logic [LOG2-1:0]                src,
    input  logic [LOG2-1:0]                dst,
    output logic [LOG2*(LOG2-1)-1:0]       path_elem,
    output logic [LOG2-1:0]                path_set
);
    localparam int STAGES = LOG2;
    localparam int EW     = LOG2 - 1;

    logic [LOG2-1:0] tag;
    logic [LOG2-1:0] line;

    always_comb begin
        tag       = src ^ dst;
        line      = src;
        path_elem = '0;
        path_set  = '0;
        for (int s = 0; s < STAGES; s++) begin
            line                  = {line[LOG2-2:0], line[LOG2-1]};
            path_elem[s*EW +: EW] = line[LOG2-1:1];
            path_set[s]           = tag[LOG2-1-s];
            line[0]               = line[0] ^ tag[LOG2-1-s];
        end
    end

endmodule

// File: rtl/omega_claim_arbiter.sv
// Claims exchange elements in ascending source order; flags setting clashes.
module omega_claim_arbiter #(
    parameter int LOG2 = 3
) (
    input  logic [(1<<LOG2)-1:0]                       req_valid,
    input  logic [(1<<LOG2)*LOG2*(LOG2-1)-1:0]         all_elem,
    input  logic [(1<<LOG2)*LOG2-1:0]                  all_set,
    output logic [(1<<LOG2)-1:0]                       accept,
    output logic [(1<<LOG2)-1:0]                       conflict,
    output logic [LOG2*(1<<(LOG2-1))-1:0]              settings
);
    localparam int N      = 1 << LOG2;
    localparam int STAGES = LOG2;
    localparam int HALF   = N / 2;
    localparam int EW     = LOG2 - 1;
    localparam int SET_W  = STAGES * HALF;

    logic [SET_W-1:0] claimed;
    logic [SET_W-1:0] value;
    logic             clash;

    always_comb begin
        claimed  = '0;
        value    = '0;
        accept   = '0;
        conflict = '0;
        clash    = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (req_valid[p]) begin
                clash = 1'b0;
                for (int s = 0; s < STAGES; s++) begin
                    if (claimed[s*HALF + int'(all_elem[(p*STAGES+s)*EW +: EW])] &&
                        (value[s*HALF + int'(all_elem[(p*STAGES+s)*EW +: EW])] != all_set[p*STAGES+s]))
                        clash = 1'b1;
                end
                if (clash) begin
                    conflict[p] = 1'b1;
                end else begin
                    accept[p] = 1'b1;
                    for (int s = 0; s < STAGES; s++) begin
                        claimed[s*HALF + int'(all_elem[(p*STAGES+s)*EW +: EW])] = 1'b1;
                        value[s*HALF + int'(all_elem[(p*STAGES+s)*EW +: EW])]   = all_set[p*STAGES+s];
                    end
                end
            end
        end
        settings = value;
    end

endmodule

// File: rtl/omega_lane_fabric.sv
// Data plane: shuffle wiring then 2x2 exchange per stage.
module omega_lane_fabric #(
    parameter int LOG2   = 3,
    parameter int LANE_W = 16
) (
    input  logic [LOG2*(1<<(LOG2-1))-1:0]   settings,
    input  logic [(1<<LOG2)*LANE_W-1:0]     data_in,
    output logic [(1<<LOG2)*LANE_W-1:0]     data_out
);
    localparam int N      = 1 << LOG2;
    localparam int STAGES = LOG2;
    localparam int HALF   = N / 2;

    logic [LANE_W-1:0] lane [STAGES+1][N];
    logic [LANE_W-1:0] shuf [STAGES][N];

    for (genvar i = 0; i < N; i++) begin : g_io
        assign lane[0][i]                    = data_in[i*LANE_W +: LANE_W];
        assign data_out[i*LANE_W +: LANE_W]  = lane[STAGES][i];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < N; i++) begin : g_shuffle
            localparam int TO = ((i << 1) | (i >> (LOG2-1))) & (N-1);
            assign shuf[s][TO] = lane[s][i];
        end
        for (genvar e = 0; e < HALF; e++) begin : g_elem
            assign lane[s+1][2*e]   = settings[s*HALF+e] ? shuf[s][2*e+1] : shuf[s][2*e];
            assign lane[s+1][2*e+1] = settings[s*HALF+e] ? shuf[s][2*e]   : shuf[s][2*e+1];
        end
    end

endmodule

// File: rtl/omega_xor_router.sv
module omega_xor_router
    import omega_cfg_pkg::*;
#(
    parameter int LOG2   = 3,
    parameter int LANE_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_start,
    input  logic [(1<<LOG2)-1:0]             req_valid,
    input  logic [(1<<LOG2)*LOG2-1:0]        req_dst,
    input  logic [(1<<LOG2)*LANE_W-1:0]      data_in,
    output logic                             cfg_done,
    output logic [(1<<LOG2)-1:0]             accept_mask,
    output logic [(1<<LOG2)-1:0]             conflict_mask,
    output logic [LOG2*(1<<(LOG2-1))-1:0]    switch_set,
    output logic [(1<<LOG2)*LANE_W-1:0]      data_out
);
    localparam int N      = 1 << LOG2;
    localparam int STAGES = LOG2;
    localparam int HALF   = N / 2;
    localparam int EW     = LOG2 - 1;
    localparam int SET_W  = STAGES * HALF;

    cfg_state_t state_q, state_nx;

    logic [N*STAGES*EW-1:0] all_elem;
    logic [N*STAGES-1:0]    all_set;
    logic [N-1:0]           acc_c, conf_c;
    logic [SET_W-1:0]       set_c;

    for (genvar p = 0; p < N; p++) begin : g_path
        omega_tag_path #(.LOG2(LOG2)) u_path (
            .src       (LOG2'(p)),
            .dst       (req_dst[p*LOG2 +: LOG2]),
            .path_elem (all_elem[p*STAGES*EW +: STAGES*EW]),
            .path_set  (all_set[p*STAGES +: STAGES])
        );
    end

    omega_claim_arbiter #(.LOG2(LOG2)) u_arb (
        .req_valid (req_valid),
        .all_elem  (all_elem),
        .all_set   (all_set),
        .accept    (acc_c),
        .conflict  (conf_c),
        .settings  (set_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   state_nx = cfg_start ? ST_REPORT : ST_IDLE;   // START_SEEN
            ST_REPORT: state_nx = cfg_start ? ST_REPORT : ST_IDLE;   // RESTART / RETIRE
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        cfg_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   cfg_done = 1'b0;
            ST_REPORT: cfg_done = 1'b1;
            default:   cfg_done = 1'b0;
        endcase
    end

    // held configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_mask   <= '0;
            conflict_mask <= '0;
            switch_set    <= '0;
        end else if (cfg_start) begin
            accept_mask   <= acc_c;
            conflict_mask <= conf_c;
            switch_set    <= set_c;
        end
    end

    omega_lane_fabric #(.LOG2(LOG2), .LANE_W(LANE_W)) u_fabric (
        .settings (switch_set),
        .data_in  (data_in),
        .data_out (data_out)
    );

endmodule

// File: rtl/omega_xor_router_chk.sv
module omega_xor_router_chk #(
    parameter int LOG2 = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_start,
    input logic [(1<<LOG2)-1:0]           req_valid,
    input logic                           cfg_done,
    input logic [(1<<LOG2)-1:0]           accept_mask,
    input logic [(1<<LOG2)-1:0]           conflict_mask,
    input logic [LOG2*(1<<(LOG2-1))-1:0]  switch_set
);
    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> $past(cfg_start));

    assert_hold_without_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_start) |-> ($stable(switch_set) && $stable(accept_mask) && $stable(conflict_mask)));

    assert_masks_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_mask & conflict_mask) == '0);

    assert_masks_cover_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> ((accept_mask | conflict_mask) == $past(req_valid)));

    assert_invalid_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> ((conflict_mask & ~$past(req_valid)) == '0));

    assert_first_source_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (conflict_mask[0] == 1'b0));

endmodule

bind omega_xor_router omega_xor_router_chk #(.LOG2(LOG2)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_start     (cfg_start),
    .req_valid     (req_valid),
    .cfg_done      (cfg_done),
    .accept_mask   (accept_mask),
    .conflict_mask (conflict_mask),
    .switch_set    (switch_set)
);

// File: tb/omega_xor_router_test.sv
module omega_xor_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOG2   = 3;
    localparam int N      = 8;
    localparam int LANE_W = 16;

    // {valid[8], dst[24], exp_acc[8], exp_conf[8], exp_set[12]}
    localparam logic [59:0] VECS [8] = '{
        {8'hFF, 24'hFAC688, 8'hFF, 8'h00, 12'h000},  // identity, all straight
        {8'h02, 24'h000010, 8'h02, 8'h00, 12'h240},  // 1 -> 2 worked path
        {8'hFF, 24'h053977, 8'hFF, 8'h00, 12'hFFF},  // complement, all crossed
        {8'hFF, 24'h000000, 8'h01, 8'hFE, 12'h000},  // all to 0: late clashes
        {8'h03, 24'h000001, 8'h03, 8'h00, 12'h100},  // 0->1, 1->0 share crossed element
        {8'h11, 24'h001000, 8'h01, 8'h10, 12'h000},  // 4->1 clashes with 0->0 at stage 0
        {8'h00, 24'hFAC688, 8'h00, 8'h00, 12'h000},  // nothing valid
        {8'h01, 24'h001000, 8'h01, 8'h00, 12'h000}   // invalid 4->1 blocks nothing
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cfg_start = 1'b0;
    logic [N-1:0]          req_valid = '0;
    logic [N*LOG2-1:0]     req_dst = '0;
    logic [N*LANE_W-1:0]   data_in = '0;
    logic                  cfg_done;
    logic [N-1:0]          accept_mask, conflict_mask;
    logic [11:0]           switch_set;
    logic [N*LANE_W-1:0]   data_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    omega_xor_router #(.LOG2(LOG2), .LANE_W(LANE_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .req_valid(req_valid),
        .req_dst(req_dst), .data_in(data_in), .cfg_done(cfg_done),
        .accept_mask(accept_mask), .conflict_mask(conflict_mask),
        .switch_set(switch_set), .data_out(data_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic configure(input logic [N-1:0] v, input logic [N*LOG2-1:0] d);
        @(negedge clk);
        req_valid = v;
        req_dst   = d;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    // R10: lane routing for every accepted source
    task automatic check_lanes(input logic [N-1:0] acc, input logic [N*LOG2-1:0] d);
        for (int p = 0; p < N; p++) begin
            if (acc[p]) begin
                int t;
                t = int'(d[p*LOG2 +: LOG2]);
                check("R10 lane", 32'(data_out[t*LANE_W +: LANE_W]), 32'(data_in[p*LANE_W +: LANE_W]));
            end
        end
    endtask

    task automatic run_tests;
        for (int i = 0; i < N; i++) data_in[i*LANE_W +: LANE_W] = 16'hA000 + 16'(i * 16'h0111);

        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 switch_set", 32'(switch_set), 32'h0);
        check("R1 accept", 32'(accept_mask), 32'h0);
        check("R1 conflict", 32'(conflict_mask), 32'h0);
        check("R1 done", 32'(cfg_done), 32'h0);
        rst_n = 1'b1;

        // table of vectors: R3 R4 R5 R6 R7 R8 R10
        for (int k = 0; k < 8; k++) begin
            logic [59:0] v;
            v = VECS[k];
            configure(v[59:52], v[51:28]);
            check("R2 done pulse", 32'(cfg_done), 32'h1);
            check("R5 accept", 32'(accept_mask), 32'(v[27:20]));
            check("R5 conflict", 32'(conflict_mask), 32'(v[19:12]));
            check("R3 R4 R6 switch_set", 32'(switch_set), 32'(v[11:0]));
            check_lanes(accept_mask, v[51:28]);
            @(negedge clk);
            check("R2 done falls", 32'(cfg_done), 32'h0);
        end

        // R9: inputs change without start, results hold and lanes keep routing
        configure(8'h02, 24'h000010);
        @(negedge clk);
        req_valid = 8'hFF;
        req_dst   = 24'h053977;
        repeat (3) @(negedge clk);
        check("R9 hold switch_set", 32'(switch_set), 32'h240);
        check("R9 hold accept", 32'(accept_mask), 32'h02);
        check("R9 hold conflict", 32'(conflict_mask), 32'h00);
        check("R9 lane 1->2", 32'(data_out[2*LANE_W +: LANE_W]), 32'(data_in[1*LANE_W +: LANE_W]));

        // R2: back-to-back starts keep done high, second result shown
        @(negedge clk);
        req_valid = 8'hFF; req_dst = 24'hFAC688; cfg_start = 1'b1;
        @(negedge clk);
        check("R2 first of pair", 32'(cfg_done), 32'h1);
        req_dst = 24'h053977;
        @(negedge clk);
        cfg_start = 1'b0;
        check("R2 second of pair", 32'(cfg_done), 32'h1);
        check("R2 second result", 32'(switch_set), 32'hFFF);

        // R11: every single request in an idle network
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                logic [N*LOG2-1:0] dv;
                dv = '0;
                dv[s*LOG2 +: LOG2] = LOG2'(d);
                configure(8'(1 << s), dv);
                check("R11 single accept", 32'(accept_mask), 32'(1 << s));
                check("R11 lane", 32'(data_out[d*LANE_W +: LANE_W]), 32'(data_in[s*LANE_W +: LANE_W]));
            end
        end

        // R1: reset clears a non-zero configuration
        configure(8'hFF, 24'h053977);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears set", 32'(switch_set), 32'h0);
        check("R1 reset clears accept", 32'(accept_mask), 32'h0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(CLK_PERIOD * 100000);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule